// File: doc/BRIEF.md
# Multi-Variant Cartridge Bank Controller

This block sits beside a CPU bus. It treats writes into the lower half of the address space (0x0000 to 0x7FFF) as commands, not as data stores. From each accepted write it keeps six things up to date:

- an external-RAM enable flag;
- a ROM bank number;
- a RAM bank number;
- a banking-mode bit;
- a 4-bit clock-register select;
- a one-cycle strobe that asks a clock block to latch its counters.

A quasi-static `mode` input picks one of three command layouts: variant A, variant B or variant C. The outputs go straight to an address decoder. That decoder builds the physical ROM and RAM addresses from them. When `clk_route` is high, it sends external-RAM accesses to the clock registers instead.

The bank counts for ROM and RAM are powers of two and are set by parameters. Every stored bank number is reduced modulo its count after each accepted write. A second parameter says which variants are built. Writes made in a variant that is not built are dropped.

Top module: `cart_bank_ctrl`

## Requirements
- R1: After reset the ROM bank is 1 (masked by the ROM bank count), the RAM bank is 0, and RAM enable, bank mode, clock select and the latch strobe are all 0.
- R2: In every variant a write to 0x0000–0x1FFF sets RAM enable to 1 when wdata[3:0] is 0xA and to 0 for any other value.
- R3: In variant A (mode 0) a write to 0x2000–0x3FFF loads ROM bank bits 4:0 from wdata[4:0], with 0 replaced by 1. Bits 6:5 are kept and bits 8:7 are cleared.
- R4: In variant A (mode 0) a write to 0x4000–0x5FFF behaves according to the bank mode bit:
  - bank mode 1: the RAM bank is loaded with wdata[1:0];
  - bank mode 0: ROM bank bits 6:5 are loaded with wdata[1:0], bits 4:0 are kept and bits 8:7 are cleared.
- R5: In variant A (mode 0) a write to 0x6000–0x7FFF loads the bank mode bit from wdata[0].
- R6: In variant B (mode 1) writes act as follows:
  - 0x2000–0x3FFF: loads a 7-bit ROM bank from wdata[6:0], with 0 replaced by 1;
  - 0x4000–0x5FFF: loads the clock select from wdata[3:0] and the RAM bank from wdata[1:0].
  
  `clk_route` always equals clock select bit 3.
- R7: In variant B (mode 1) a write to 0x6000–0x7FFF leaves the bank state unchanged. It raises `latch_pulse` for exactly one cycle after the write edge, with `latch_data` equal to the written byte.
- R8: In variant C (mode 2) writes act as follows:
  - 0x2000–0x2FFF: loads ROM bank bits 7:0 from wdata, with 0 replaced by 1, and keeps bit 8;
  - 0x3000–0x3FFF: loads ROM bank bit 8 from wdata[0];
  - 0x4000–0x5FFF: loads a 4-bit RAM bank from wdata[3:0];
  - 0x6000–0x7FFF: has no effect.
- R9: After every accepted write the ROM bank is ANDed with (ROM_BANKS−1) and the RAM bank with (RAM_BANKS−1). The zero-to-one substitution happens before this mask.
- R10: A write has no effect on any output when any of these holds:
  - wr_en is low;
  - addr[15] is 1;
  - mode is 3;
  - the selected variant is absent from VARIANTS_PRESENT (bit 0 = A, bit 1 = B, bit 2 = C).
- R11: A write sampled at a rising clock edge is visible on the outputs right after that edge and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Variant select: 0 = A, 1 = B, 2 = C, 3 = none |
| wr_en | input | 1 | CPU write strobe |
| addr | input | 16 | CPU address |
| wdata | input | 8 | CPU write data |
| ram_en | output | 1 | External RAM enabled |
| rom_bank | output | $clog2(ROM_BANKS) | Switchable ROM bank number |
| ram_bank | output | $clog2(RAM_BANKS) | External RAM bank number |
| bank_mode | output | 1 | Variant A banking-mode bit |
| clk_sel | output | 4 | Clock-register select |
| clk_route | output | 1 | Send external RAM accesses to the clock registers |
| latch_pulse | output | 1 | One-cycle clock-latch strobe |
| latch_data | output | 8 | Byte written with the latch strobe |

## Verification
A single sequence of writes walks every address window of each variant in turn. The state carries over from one variant into the next, so later writes have to keep or clear bits set earlier. Several writes and their outcomes tell specific faults apart:
- Data values whose masked field is zero but whose other bits are set separate a correct zero test from one made on the whole byte.
- Writes of 0xA with different high nibbles, and of 0xB, separate a low-nibble test from a full-byte compare.
- Writes in variant A under both bank-mode settings show whether the mode bit steers the upper window.
- A variant A write issued after variant C has set bit 8 shows whether the upper ROM bits are cleared.

A second instance with tiny bank counts and only variant C built exposes two more faults: masking applied before the zero substitution, and writes in a variant that is not built still taking effect.

// File: rtl/cbc_pkg.sv
package cbc_pkg;

   localparam int CBC_ROM_W = 9;
   localparam int CBC_RAM_W = 4;
   localparam int CBC_SEL_W = 4;

   typedef enum logic [1:0] {
      CBC_MODE_A    = 2'd0,
      CBC_MODE_B    = 2'd1,
      CBC_MODE_C    = 2'd2,
      CBC_MODE_NONE = 2'd3
   } cbc_mode_e;

   typedef struct packed {
      logic                 ram_en;
      logic [CBC_ROM_W-1:0] rom;
      logic [CBC_RAM_W-1:0] ram;
      logic                 bmode;
      logic [CBC_SEL_W-1:0] csel;
   } cbc_state_t;

   function automatic logic cbc_enable_code(input logic [7:0] d);
      return d[3:0] == 4'hA;
   endfunction

endpackage

// File: rtl/cbc_ctl_a.sv
module cbc_ctl_a
   import cbc_pkg::*;
(
   input  cbc_state_t cur,
   input  logic [3:0] page,
   input  logic [7:0] data,
   output cbc_state_t nxt
);
   logic [4:0] lo5;

   assign lo5 = (data[4:0] == 5'd0) ? 5'd1 : data[4:0];

   always_comb begin
      nxt = cur;
      case (page[3:1])
         3'b000: nxt.ram_en = cbc_enable_code(data);
         3'b001: nxt.rom    = {2'b00, cur.rom[6:5], lo5};
         3'b010: begin
            if (cur.bmode) nxt.ram = {2'b00, data[1:0]};
            else           nxt.rom = {2'b00, data[1:0], cur.rom[4:0]};
         end
         3'b011: nxt.bmode  = data[0];
         default: ;
      endcase
   end
endmodule

// File: rtl/cbc_ctl_b.sv
module cbc_ctl_b
   import cbc_pkg::*;
(
   input  cbc_state_t cur,
   input  logic [3:0] page,
   input  logic [7:0] data,
   output cbc_state_t nxt,
   output logic       latch_req
);
   logic [6:0] lo7;

   assign lo7 = (data[6:0] == 7'd0) ? 7'd1 : data[6:0];

   always_comb begin
      nxt       = cur;
      latch_req = 1'b0;
      case (page[3:1])
         3'b000: nxt.ram_en = cbc_enable_code(data);
         3'b001: nxt.rom    = {2'b00, lo7};
         3'b010: begin
            nxt.csel = data[3:0];
            nxt.ram  = {2'b00, data[1:0]};
         end
         3'b011: latch_req  = 1'b1;
         default: ;
      endcase
   end
endmodule

// File: rtl/cbc_ctl_c.sv
module cbc_ctl_c
   import cbc_pkg::*;
(
   input  cbc_state_t cur,
   input  logic [3:0] page,
   input  logic [7:0] data,
   output cbc_state_t nxt
);
   logic [7:0] lo8;

   assign lo8 = (data == 8'd0) ? 8'd1 : data;

   always_comb begin
      nxt = cur;
      case (page)
         4'h0, 4'h1: nxt.ram_en = cbc_enable_code(data);
         4'h2:       nxt.rom    = {cur.rom[8], lo8};
         4'h3:       nxt.rom    = {data[0], cur.rom[7:0]};
         4'h4, 4'h5: nxt.ram    = data[3:0];
         default: ;
      endcase
   end
endmodule

// File: rtl/cart_bank_ctrl.sv
module cart_bank_ctrl
   import cbc_pkg::*;
#(
   parameter int         ROM_BANKS        = 512,
   parameter int         RAM_BANKS        = 16,
   parameter logic [2:0] VARIANTS_PRESENT = 3'b111,
   localparam int        ROM_BW           = $clog2(ROM_BANKS),
   localparam int        RAM_BW           = $clog2(RAM_BANKS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        mode,
   input  logic              wr_en,
   input  logic [15:0]       addr,
   input  logic [7:0]        wdata,
   output logic              ram_en,
   output logic [ROM_BW-1:0] rom_bank,
   output logic [RAM_BW-1:0] ram_bank,
   output logic              bank_mode,
   output logic [3:0]        clk_sel,
   output logic              clk_route,
   output logic              latch_pulse,
   output logic [7:0]        latch_data
);
   localparam logic [CBC_ROM_W-1:0] ROM_MASK = CBC_ROM_W'(ROM_BANKS - 1);
   localparam logic [CBC_RAM_W-1:0] RAM_MASK = CBC_RAM_W'(RAM_BANKS - 1);
   localparam cbc_state_t RST_STATE = '{ram_en: 1'b0, rom: CBC_ROM_W'(1) & ROM_MASK,
                                        ram: '0, bmode: 1'b0, csel: '0};

   // elaboration-time parameter checks
   if (ROM_BANKS < 2 || ROM_BANKS > 512 || (ROM_BANKS & (ROM_BANKS - 1)) != 0) begin : g_bad_rom
      $error("ROM_BANKS must be a power of two from 2 to 512");
   end
   if (RAM_BANKS < 2 || RAM_BANKS > 16 || (RAM_BANKS & (RAM_BANKS - 1)) != 0) begin : g_bad_ram
      $error("RAM_BANKS must be a power of two from 2 to 16");
   end

   cbc_state_t st_q, nxt_a, nxt_b, nxt_c, sel_nxt, masked;
   logic       lat_b, sel_lat, mode_ok, accept, lat_q;
   logic [7:0] lat_d;
   cbc_mode_e  mode_e;

   assign mode_e = cbc_mode_e'(mode);

   if (VARIANTS_PRESENT[0]) begin : g_var_a
      cbc_ctl_a u_a (.cur(st_q), .page(addr[15:12]), .data(wdata), .nxt(nxt_a));
   end else begin : g_no_a
      assign nxt_a = st_q;
   end

   if (VARIANTS_PRESENT[1]) begin : g_var_b
      cbc_ctl_b u_b (.cur(st_q), .page(addr[15:12]), .data(wdata), .nxt(nxt_b), .latch_req(lat_b));
   end else begin : g_no_b
      assign nxt_b = st_q;
      assign lat_b = 1'b0;
   end

   if (VARIANTS_PRESENT[2]) begin : g_var_c
      cbc_ctl_c u_c (.cur(st_q), .page(addr[15:12]), .data(wdata), .nxt(nxt_c));
   end else begin : g_no_c
      assign nxt_c = st_q;
   end

   always_comb begin
      sel_nxt = st_q;
      sel_lat = 1'b0;
      mode_ok = 1'b0;
      case (mode_e)
         CBC_MODE_A: begin sel_nxt = nxt_a; mode_ok = VARIANTS_PRESENT[0]; end
         CBC_MODE_B: begin sel_nxt = nxt_b; sel_lat = lat_b; mode_ok = VARIANTS_PRESENT[1]; end
         CBC_MODE_C: begin sel_nxt = nxt_c; mode_ok = VARIANTS_PRESENT[2]; end
         default: ;
      endcase
   end

   assign accept = wr_en && !addr[15] && mode_ok;

   always_comb begin
      masked     = sel_nxt;
      masked.rom = sel_nxt.rom & ROM_MASK;
      masked.ram = sel_nxt.ram & RAM_MASK;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q  <= RST_STATE;
         lat_q <= 1'b0;
         lat_d <= 8'h00;
      end else begin
         lat_q <= accept && sel_lat;
         if (accept) st_q <= masked;
         if (accept && sel_lat) lat_d <= wdata;
      end
   end

   assign ram_en      = st_q.ram_en;
   assign rom_bank    = st_q.rom[ROM_BW-1:0];
   assign ram_bank    = st_q.ram[RAM_BW-1:0];
   assign bank_mode   = st_q.bmode;
   assign clk_sel     = st_q.csel;
   assign clk_route   = st_q.csel[3];
   assign latch_pulse = lat_q;
   assign latch_data  = lat_d;

   // R1: state right after reset release
   a_r1_reset_vals: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (rom_bank == ROM_BW'(1) && ram_bank == '0 && !ram_en
                        && !bank_mode && clk_sel == 4'h0 && !latch_pulse));

   // R2: enable window follows the low nibble of the data
   a_r2_enable_cmd: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && addr[15:13] == 3'b000) |=> (ram_en == ($past(wdata[3:0]) == 4'hA)));

   // R3: variant A low window never leaves bits 4:0 at zero with enough banks
   a_r3_no_zero_low: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && mode_e == CBC_MODE_A && addr[15:13] == 3'b001 && ROM_BANKS >= 32)
      |=> (st_q.rom[4:0] != 5'd0));

   // R7: strobe only follows a variant B write to the latch window
   a_r7_latch_source: assert property (@(posedge clk) disable iff (!rst_n)
      latch_pulse |-> ($past(wr_en) && $past(addr[15:13]) == 3'b011 && $past(mode) == 2'd1));

   // R8: variant C bit-8 window
   a_r8_c_bit8: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && mode_e == CBC_MODE_C && addr[15:12] == 4'h3)
      |=> (st_q.rom[8] == ($past(wdata[0]) & ROM_MASK[8])));

   // R10: rejected cycles leave every output alone
   a_r10_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      !accept |=> ($stable(rom_bank) && $stable(ram_bank) && $stable(ram_en)
                   && $stable(bank_mode) && $stable(clk_sel) && !latch_pulse));
endmodule

// File: tb/tb_cart_bank_ctrl.sv
module tb_cart_bank_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  mode = 2'd0, mode_m = 2'd0;
   logic        wr_en = 1'b0, wr_m = 1'b0;
   logic [15:0] addr = 16'h0;
   logic [7:0]  wdata = 8'h0;

   logic       ram_en, bank_mode, clk_route, latch_pulse;
   logic [8:0] rom_bank;
   logic [3:0] ram_bank, clk_sel;
   logic [7:0] latch_data;

   logic       en_m, bm_m, route_m, lp_m;
   logic [1:0] rom_m;
   logic [0:0] ram_m;
   logic [3:0] cs_m;
   logic [7:0] ld_m;

   int  checks = 0, errors = 0;
   bit  done = 0;

   always #5 clk = ~clk;

   cart_bank_ctrl dut (
      .clk(clk), .rst_n(rst_n), .mode(mode), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .ram_en(ram_en), .rom_bank(rom_bank), .ram_bank(ram_bank), .bank_mode(bank_mode),
      .clk_sel(clk_sel), .clk_route(clk_route), .latch_pulse(latch_pulse), .latch_data(latch_data));

   cart_bank_ctrl #(.ROM_BANKS(4), .RAM_BANKS(2), .VARIANTS_PRESENT(3'b100)) dut_m (
      .clk(clk), .rst_n(rst_n), .mode(mode_m), .wr_en(wr_m), .addr(addr), .wdata(wdata),
      .ram_en(en_m), .rom_bank(rom_m), .ram_bank(ram_m), .bank_mode(bm_m),
      .clk_sel(cs_m), .clk_route(route_m), .latch_pulse(lp_m), .latch_data(ld_m));

   // req, mode, addr, data, exp rom, exp ram, exp en, exp bmode, exp csel, exp pulse
   localparam int NV = 27;
   localparam logic [49:0] VEC [NV] = '{
      {4'd2, 2'd0, 16'h0000, 8'h0A, 9'h001, 4'h0, 1'b1, 1'b0, 4'h0, 1'b0},  // R2
      {4'd2, 2'd0, 16'h1FFF, 8'h1B, 9'h001, 4'h0, 1'b0, 1'b0, 4'h0, 1'b0},  // R2
      {4'd2, 2'd0, 16'h0100, 8'hFA, 9'h001, 4'h0, 1'b1, 1'b0, 4'h0, 1'b0},  // R2
      {4'd3, 2'd0, 16'h2000, 8'h00, 9'h001, 4'h0, 1'b1, 1'b0, 4'h0, 1'b0},  // R3
      {4'd3, 2'd0, 16'h3FFF, 8'h13, 9'h013, 4'h0, 1'b1, 1'b0, 4'h0, 1'b0},  // R3
      {4'd4, 2'd0, 16'h4000, 8'h02, 9'h053, 4'h0, 1'b1, 1'b0, 4'h0, 1'b0},  // R4
      {4'd3, 2'd0, 16'h2100, 8'hE0, 9'h041, 4'h0, 1'b1, 1'b0, 4'h0, 1'b0},  // R3
      {4'd5, 2'd0, 16'h6000, 8'h01, 9'h041, 4'h0, 1'b1, 1'b1, 4'h0, 1'b0},  // R5
      {4'd4, 2'd0, 16'h5000, 8'h03, 9'h041, 4'h3, 1'b1, 1'b1, 4'h0, 1'b0},  // R4
      {4'd5, 2'd0, 16'h7000, 8'hFE, 9'h041, 4'h3, 1'b1, 1'b0, 4'h0, 1'b0},  // R5
      {4'd6, 2'd1, 16'h2000, 8'h80, 9'h001, 4'h3, 1'b1, 1'b0, 4'h0, 1'b0},  // R6
      {4'd6, 2'd1, 16'h3000, 8'hFF, 9'h07F, 4'h3, 1'b1, 1'b0, 4'h0, 1'b0},  // R6
      {4'd6, 2'd1, 16'h4000, 8'h2B, 9'h07F, 4'h3, 1'b1, 1'b0, 4'hB, 1'b0},  // R6
      {4'd7, 2'd1, 16'h6000, 8'h5A, 9'h07F, 4'h3, 1'b1, 1'b0, 4'hB, 1'b1},  // R7
      {4'd6, 2'd1, 16'h4000, 8'h05, 9'h07F, 4'h1, 1'b1, 1'b0, 4'h5, 1'b0},  // R6
      {4'd2, 2'd1, 16'h0000, 8'h00, 9'h07F, 4'h1, 1'b0, 1'b0, 4'h5, 1'b0},  // R2
      {4'd2, 2'd2, 16'h1000, 8'h3A, 9'h07F, 4'h1, 1'b1, 1'b0, 4'h5, 1'b0},  // R2
      {4'd8, 2'd2, 16'h3000, 8'h01, 9'h17F, 4'h1, 1'b1, 1'b0, 4'h5, 1'b0},  // R8
      {4'd8, 2'd2, 16'h2000, 8'h00, 9'h101, 4'h1, 1'b1, 1'b0, 4'h5, 1'b0},  // R8
      {4'd8, 2'd2, 16'h2FFF, 8'hC4, 9'h1C4, 4'h1, 1'b1, 1'b0, 4'h5, 1'b0},  // R8
      {4'd8, 2'd2, 16'h3000, 8'h00, 9'h0C4, 4'h1, 1'b1, 1'b0, 4'h5, 1'b0},  // R8
      {4'd8, 2'd2, 16'h5FFF, 8'h0E, 9'h0C4, 4'hE, 1'b1, 1'b0, 4'h5, 1'b0},  // R8
      {4'd8, 2'd2, 16'h6000, 8'hFF, 9'h0C4, 4'hE, 1'b1, 1'b0, 4'h5, 1'b0},  // R8
      {4'd10, 2'd2, 16'hA000, 8'h00, 9'h0C4, 4'hE, 1'b1, 1'b0, 4'h5, 1'b0}, // R10
      {4'd10, 2'd3, 16'h2000, 8'h05, 9'h0C4, 4'hE, 1'b1, 1'b0, 4'h5, 1'b0}, // R10
      {4'd10, 2'd3, 16'h0000, 8'h00, 9'h0C4, 4'hE, 1'b1, 1'b0, 4'h5, 1'b0}, // R10
      {4'd3, 2'd0, 16'h2000, 8'h07, 9'h047, 4'hE, 1'b1, 1'b0, 4'h5, 1'b0}   // R3
   };

   task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", what, act, exp);
      end
   endtask

   task automatic wr_main(input logic [1:0] m, input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      mode = m; addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic wr_small(input logic [1:0] m, input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      mode_m = m; addr = a; wdata = d; wr_m = 1'b1;
      @(negedge clk);
      wr_m = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 rom_bank", 32'(rom_bank), 32'h1);
      chk("R1 ram_bank", 32'(ram_bank), 32'h0);
      chk("R1 ram_en", 32'(ram_en), 32'h0);
      chk("R1 bank_mode", 32'(bank_mode), 32'h0);
      chk("R1 clk_sel", 32'(clk_sel), 32'h0);
      chk("R1 latch_pulse", 32'(latch_pulse), 32'h0);
      chk("R1 small rom_bank", 32'(rom_m), 32'h1);

      for (int i = 0; i < NV; i++) begin
         logic [49:0] v;
         string t;
         v = VEC[i];
         wr_main(v[45:44], v[43:28], v[27:20]);
         t = $sformatf("R%0d vec%0d", v[49:46], i);
         chk({t, " rom_bank"}, 32'(rom_bank), 32'(v[19:11]));
         chk({t, " ram_bank"}, 32'(ram_bank), 32'(v[10:7]));
         chk({t, " ram_en"}, 32'(ram_en), 32'(v[6]));
         chk({t, " bank_mode"}, 32'(bank_mode), 32'(v[5]));
         chk({t, " clk_sel"}, 32'(clk_sel), 32'(v[4:1]));
         chk({t, " clk_route R6"}, 32'(clk_route), 32'(v[4]));
         chk({t, " latch_pulse"}, 32'(latch_pulse), 32'(v[0]));
         if (v[0]) chk({t, " latch_data R7"}, 32'(latch_data), 32'h5A);
         @(negedge clk);
         chk({t, " R7 pulse single cycle"}, 32'(latch_pulse), 32'h0);
      end

      // R10: wr_en low has no effect
      @(negedge clk);
      mode = 2'd0; addr = 16'h2000; wdata = 8'h09; wr_en = 1'b0;
      repeat (2) @(negedge clk);
      chk("R10 wr_en low rom_bank", 32'(rom_bank), 32'h047);

      // R11: not before the edge, right after it
      @(negedge clk);
      mode = 2'd0; addr = 16'h0000; wdata = 8'h00; wr_en = 1'b1;
      #3;
      chk("R11 before edge ram_en", 32'(ram_en), 32'h1);
      @(posedge clk);
      #1;
      chk("R11 after edge ram_en", 32'(ram_en), 32'h0);
      @(negedge clk);
      wr_en = 1'b0;

      // R10: variant A absent from the small instance
      wr_small(2'd0, 16'h0000, 8'h0A);
      chk("R10 absent variant ram_en", 32'(en_m), 32'h0);
      wr_small(2'd0, 16'h2000, 8'h02);
      chk("R10 absent variant rom_bank", 32'(rom_m), 32'h1);
      // R9 masking with 4 ROM banks and 2 RAM banks
      wr_small(2'd2, 16'h2000, 8'hFF);
      chk("R9 rom mask 0xFF", 32'(rom_m), 32'h3);
      wr_small(2'd2, 16'h2000, 8'h04);
      chk("R9 mask after zero substitution", 32'(rom_m), 32'h0);
      wr_small(2'd2, 16'h4000, 8'h0F);
      chk("R9 ram mask", 32'(ram_m), 32'h1);
      wr_small(2'd2, 16'h3000, 8'h01);
      chk("R9 bit8 masked away", 32'(rom_m), 32'h0);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule